// File: doc/BRIEF.md
# Pad Interrupt Router with Per-Channel Sensing

This block watches a wide bank of chip pads and steers a single chosen pad onto each of eight interrupt channels. Each channel picks its own pad, decides whether it senses a level or an edge, and decides whether the active sense is high or low. An optional per-channel glitch filter can demand that a change persist before the channel reacts. Whatever the chosen sense, every output is active-high toward the downstream interrupt controller: a level that follows the corrected pad state in level mode, and a single-cycle pulse in edge mode.

Software configures the router through a small register port with separate write and read strobes, a byte address and a 32-bit data bus. The port is always ready: a write lands on the next clock edge, and read data appears on the bus one cycle after the read strobe, so there is no back-pressure on either side. Pad inputs are asynchronous and pass through a two-stage synchronizer before selection. The pad count is a build parameter (typical builds use 119, 133 or 134 pads), and the 8-bit select field addresses all of them.

Top module: `padirq_router`

## Requirements
- R1: After reset every register reads zero and all eight interrupt outputs are low.
- R2: Register words are decoded from address bits [3:2]: 0x0 is sensing (bit x = edge mode for channel x, bit 16+x = low polarity for channel x, other bits read zero); 0x4 holds pad selects of channels 0 to 3 and 0x8 those of channels 4 to 7, each 8 bits wide at bit (x mod 4)*8; 0xC holds a 4-bit filter value for channel x at bit 4*x. A write takes effect on the next clock edge and a read returns the word one cycle after the read strobe.
- R3: Any pad index below the pad count, including the highest one, can be routed to any channel; in level mode with high polarity and filter 0, the output follows the pad three clock edges after the pad changes.
- R4: In level mode with low polarity, the output is the inverse of the selected pad level.
- R5: In edge mode with high polarity, a rising pad edge gives exactly one output pulse of one clock cycle, and a falling edge gives none.
- R6: In edge mode with low polarity, a falling pad edge gives exactly one single-cycle pulse and a rising edge gives none; no setting reacts to both edges.
- R7: With filter value N greater than 0, the polarity-corrected signal must differ from the filtered state for N*4 consecutive cycles before the filtered state takes the new value; shorter excursions have no effect at the output. N = 0 passes every change.
- R8: A select value at or above the pad count makes the channel see a constant low pad, so a level-mode, high-polarity channel stays low whatever the pads do.
- R9: Channels are independent: every output matches its own configuration and pad under mixed settings and changing pads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pads_i | input | NUM_PADS | Asynchronous pad levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid one cycle after the read strobe |
| irq_o | output | 8 | Active-high interrupt outputs, one per channel |

## Verification
The routing path is tried with single pads at both ends of the pad range driven in steps, which separates a correct three-edge latency from an off-by-one in the synchronizer or a wrong index. Edge channels receive a full rise-and-fall cycle of their pad, so a pulse counted on the wrong edge, a pulse on both edges or a pulse stretched beyond one cycle each show up as a wrong count. The filter is given a glitch shorter than its window followed by a long hold, telling a working filter apart from a bypassed or miscounting one, and a long run of random pads under random mixed settings is compared against a cycle-accurate behavioural model on every clock.

// File: rtl/padirq_pkg.sv
package padirq_pkg;
  localparam int NUM_CH = 8;
  localparam int SEL_W  = 8;
  localparam int FILT_W = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    W_SENSE  = 2'd0,
    W_SEL_LO = 2'd1,
    W_SEL_HI = 2'd2,
    W_FILT   = 2'd3
  } reg_word_e;

  typedef struct packed {
    logic              edge_md;
    logic              low_pol;
    logic [SEL_W-1:0]  sel;
    logic [FILT_W-1:0] filt;
  } ch_cfg_t;
endpackage

// File: rtl/padirq_regs.sv
module padirq_regs
  import padirq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr_i,
  input  logic                    reg_rd_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [DATA_W-1:0]       reg_wdata_i,
  output logic [DATA_W-1:0]       reg_rdata_o,
  output ch_cfg_t [NUM_CH-1:0]    cfg_o
);
  localparam int PER_WORD = DATA_W / SEL_W;

  reg_word_e         word;
  logic [NUM_CH-1:0] edge_q;
  logic [NUM_CH-1:0] low_q;
  logic [SEL_W-1:0]  sel_q  [NUM_CH];
  logic [FILT_W-1:0] filt_q [NUM_CH];
  logic [DATA_W-1:0] rd_mux;
  logic              unused_bits;

  assign word        = reg_word_e'(reg_addr_i[3:2]);
  assign unused_bits = ^{reg_addr_i[1:0], reg_wdata_i[15:8], reg_wdata_i[31:24]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      low_q  <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        sel_q[c]  <= '0;
        filt_q[c] <= '0;
      end
    end else if (reg_wr_i) begin
      if (word == W_SENSE) begin
        edge_q <= reg_wdata_i[NUM_CH-1:0];
        low_q  <= reg_wdata_i[16 +: NUM_CH];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (word == ((c < PER_WORD) ? W_SEL_LO : W_SEL_HI))
          sel_q[c] <= reg_wdata_i[(c % PER_WORD)*SEL_W +: SEL_W];
        if (word == W_FILT)
          filt_q[c] <= reg_wdata_i[c*FILT_W +: FILT_W];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (word)
      W_SENSE: begin
        rd_mux[NUM_CH-1:0]   = edge_q;
        rd_mux[16 +: NUM_CH] = low_q;
      end
      W_SEL_LO: for (int c = 0; c < PER_WORD; c++) rd_mux[c*SEL_W +: SEL_W] = sel_q[c];
      W_SEL_HI: for (int c = 0; c < PER_WORD; c++) rd_mux[c*SEL_W +: SEL_W] = sel_q[c+PER_WORD];
      default:  for (int c = 0; c < NUM_CH; c++)   rd_mux[c*FILT_W +: FILT_W] = filt_q[c];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_mux;
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      cfg_o[c].edge_md = edge_q[c];
      cfg_o[c].low_pol = low_q[c];
      cfg_o[c].sel     = sel_q[c];
      cfg_o[c].filt    = filt_q[c];
    end
  end

  // R2: a filter-word write is visible in the channel configuration one edge later
  a_r2_filt_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && word == W_FILT) |=> (cfg_o[NUM_CH-1].filt == $past(reg_wdata_i[DATA_W-1 -: FILT_W])));
endmodule

// File: rtl/padirq_sync.sv
module padirq_sync #(
  parameter int WIDTH = 134
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [1:0]       age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_o <= '0;
    end else begin
      meta_q <= async_i;
      sync_o <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R3: synchronized pads lag the raw pads by exactly two edges
  a_r3_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (sync_o == $past(async_i, 2)));
endmodule

// File: rtl/padirq_channel.sv
module padirq_channel
  import padirq_pkg::*;
#(
  parameter int NUM_PADS  = 134,
  parameter int FILT_STEP = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pads_i,
  input  ch_cfg_t             cfg_i,
  output logic                irq_o
);
  localparam int MAX_HOLD = ((1 << FILT_W) - 1) * FILT_STEP;
  localparam int CNT_W    = $clog2(MAX_HOLD + 1);

  logic             pad_bit;
  logic             raw;
  logic             filt_q;
  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             hold_met;

  always_comb begin
    pad_bit = 1'b0;
    for (int p = 0; p < NUM_PADS; p++)
      if (cfg_i.sel == SEL_W'(p)) pad_bit = pads_i[p];
  end

  assign raw      = pad_bit ^ cfg_i.low_pol;
  assign limit    = CNT_W'(cfg_i.filt) * CNT_W'(FILT_STEP);
  assign hold_met = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= filt_q;
      if (raw == filt_q) begin
        cnt_q <= '0;
      end else if (hold_met) begin
        filt_q <= raw;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign irq_o = cfg_i.edge_md ? (filt_q & ~prev_q) : filt_q;

  // R5: an edge-mode pulse never lasts two cycles
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.edge_md && irq_o) |=> (!irq_o || !cfg_i.edge_md));

  // R7: the filtered state only ever moves to the value the input had
  a_r7_filter_target: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> (filt_q == $past(raw)));

  // R8: an out-of-range select reads as a low pad
  a_r8_oor_low: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg_i.sel) >= NUM_PADS) |-> (pad_bit == 1'b0));
endmodule

// File: rtl/padirq_router.sv
module padirq_router
  import padirq_pkg::*;
#(
  parameter int NUM_PADS  = 134,
  parameter int FILT_STEP = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pads_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [3:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic [7:0]          irq_o
);
  ch_cfg_t [NUM_CH-1:0] cfg;
  logic [NUM_PADS-1:0]  pads_sync;

  padirq_regs i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .cfg_o       (cfg)
  );

  padirq_sync #(.WIDTH(NUM_PADS)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pads_i),
    .sync_o  (pads_sync)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    padirq_channel #(.NUM_PADS(NUM_PADS), .FILT_STEP(FILT_STEP)) i_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .pads_i (pads_sync),
      .cfg_i  (cfg[c]),
      .irq_o  (irq_o[c])
    );
  end

  // R1: outputs stay low in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    (!rst_n) |=> (irq_o == '0));
endmodule

// File: tb/test_padirq_router.sv
module test_padirq_router;
  localparam int NP = 134;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pads = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [7:0]    irq;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit cmp_en = 1'b0;
  bit finished = 1'b0;

  always #4ns clk = ~clk;

  padirq_router #(.NUM_PADS(NP), .FILT_STEP(4)) i_padirq_router (
    .clk(clk), .rst_n(rst_n), .pads_i(pads),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  // behavioural reference model
  logic [NP-1:0] m_s1, m_s2;
  int  m_sel[8], m_fsel[8], m_cnt[8];
  bit  m_edge[8], m_low[8], m_filt[8], m_prev[8];
  int  lim;
  bit  rawb;
  logic [7:0] m_exp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0;
      for (int c = 0; c < 8; c++) begin
        m_sel[c] = 0; m_fsel[c] = 0; m_cnt[c] = 0;
        m_edge[c] = 0; m_low[c] = 0; m_filt[c] = 0; m_prev[c] = 0;
      end
    end else begin
      for (int c = 0; c < 8; c++) begin
        lim  = m_fsel[c] * 4;
        rawb = ((m_sel[c] < NP) ? m_s2[m_sel[c]] : 1'b0) ^ m_low[c];
        m_prev[c] = m_filt[c];
        if (rawb != m_filt[c]) begin
          if (m_cnt[c] + 1 >= lim) begin m_filt[c] = rawb; m_cnt[c] = 0; end
          else m_cnt[c]++;
        end else m_cnt[c] = 0;
      end
      m_s2 = m_s1; m_s1 = pads;
      if (reg_wr) begin
        for (int c = 0; c < 8; c++) begin
          case (reg_addr[3:2])
            2'd0: begin m_edge[c] = reg_wdata[c]; m_low[c] = reg_wdata[16+c]; end
            2'd1: if (c < 4)  m_sel[c] = int'(reg_wdata[(c%4)*8 +: 8]);
            2'd2: if (c >= 4) m_sel[c] = int'(reg_wdata[(c%4)*8 +: 8]);
            default: m_fsel[c] = int'(reg_wdata[c*4 +: 4]);
          endcase
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  int pulses[8];
  always @(negedge clk) begin
    for (int c = 0; c < 8; c++) if (irq[c]) pulses[c]++;
    if (cmp_en) begin
      for (int c = 0; c < 8; c++)
        m_exp[c] = m_edge[c] ? (m_filt[c] & ~m_prev[c]) : m_filt[c];
      check(irq == m_exp, cur_req, irq, m_exp);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic clr();
    for (int c = 0; c < 8; c++) pulses[c] = 0;
  endtask

  initial begin
    #(8ns * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1: reset state
    check(irq == 8'h00, "R1", irq, 0);
    for (int a = 0; a < 4; a++) begin
      rd(4'(a*4), d);
      check(d == 32'h0, "R1", d, 0);
    end
    cmp_en = 1'b1;

    // R2: register layout and readback
    cur_req = "R2";
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, d); check(d == 32'h00FF_00FF, "R2", d, 32'h00FF_00FF);
    wr(4'h4, 32'h8040_2010); rd(4'h4, d); check(d == 32'h8040_2010, "R2", d, 32'h8040_2010);
    wr(4'h9, 32'h0102_0304); rd(4'h8, d); check(d == 32'h0102_0304, "R2", d, 32'h0102_0304);
    wr(4'hC, 32'hFEDC_BA98); rd(4'hC, d); check(d == 32'hFEDC_BA98, "R2", d, 32'hFEDC_BA98);
    wr(4'h0, 32'h0); wr(4'h4, 32'h0); wr(4'h8, 32'h0); wr(4'hC, 32'h0);
    tick(70);

    // R3: routing of the extreme pads with three-edge latency
    cur_req = "R3";
    wr(4'h4, 32'h0000_0085);          // ch0 <- pad 133
    wr(4'h8, 32'h0000_0000);          // ch7 <- pad 0 (field at bit 24 is zero)
    tick(4);
    @(negedge clk); pads[133] = 1'b1; pads[0] = 1'b1;
    tick(2); check(irq[0] == 1'b0, "R3", irq[0], 0);
    tick(1); check(irq[0] == 1'b1, "R3", irq[0], 1);
    check(irq[7] == 1'b1, "R3", irq[7], 1);
    pads[133] = 1'b0; pads[0] = 1'b0;
    tick(4); check(irq[0] == 1'b0, "R3", irq[0], 0);

    // R4: level low polarity on ch1 <- pad 10
    cur_req = "R4";
    wr(4'h4, 32'h0000_0A85);
    wr(4'h0, 32'h0002_0000);
    tick(4); check(irq[1] == 1'b1, "R4", irq[1], 1);
    pads[10] = 1'b1; tick(4); check(irq[1] == 1'b0, "R4", irq[1], 0);
    pads[10] = 1'b0; tick(4); check(irq[1] == 1'b1, "R4", irq[1], 1);

    // R5: edge high polarity on ch2 <- pad 20
    cur_req = "R5";
    wr(4'h4, 32'h0014_0A85);
    wr(4'h0, 32'h0002_0004);
    tick(4); clr();
    pads[20] = 1'b1; tick(8); check(pulses[2] == 1, "R5", pulses[2], 1);
    clr(); pads[20] = 1'b0; tick(8); check(pulses[2] == 0, "R5", pulses[2], 0);

    // R6: edge low polarity on ch4 <- pad 40
    cur_req = "R6";
    pads[40] = 1'b1;
    wr(4'h8, 32'h0000_0028);
    tick(4);
    wr(4'h0, 32'h0012_0014);
    tick(4); clr();
    pads[40] = 1'b0; tick(8); check(pulses[4] == 1, "R6", pulses[4], 1);
    clr(); pads[40] = 1'b1; tick(8); check(pulses[4] == 0, "R6", pulses[4], 0);

    // R7: filter value 2 (8 cycles) on ch5 <- pad 30
    cur_req = "R7";
    wr(4'h8, 32'h0000_1E28);
    wr(4'hC, 32'h0020_0000);
    tick(4);
    pads[30] = 1'b1; tick(5); pads[30] = 1'b0; tick(14);
    check(irq[5] == 1'b0, "R7", irq[5], 0);
    pads[30] = 1'b1; tick(7); check(irq[5] == 1'b0, "R7", irq[5], 0);
    tick(6); check(irq[5] == 1'b1, "R7", irq[5], 1);
    pads[30] = 1'b0; tick(14); check(irq[5] == 1'b0, "R7", irq[5], 0);

    // R8: out-of-range selects on ch6 (134, then 200)
    cur_req = "R8";
    wr(4'h8, 32'h0086_1E28);
    pads = '1; tick(6); check(irq[6] == 1'b0, "R8", irq[6], 0);
    wr(4'h8, 32'h00C8_1E28);
    tick(6); check(irq[6] == 1'b0, "R8", irq[6], 0);
    pads = '0; tick(20);

    // R9: random mixed configuration and pads, compared every cycle
    cur_req = "R9";
    for (int round = 0; round < 6; round++) begin
      wr(4'h0, $urandom());
      wr(4'h4, $urandom() % 32'h8686_8686);
      wr(4'h8, $urandom());
      wr(4'hC, $urandom() & 32'h3333_3333);
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if ($urandom_range(0, 3) == 0) pads = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
      end
    end
    tick(5);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule